// File: doc/BRIEF.md
# Store Ordering and Issue Unit

This unit holds stores that a processor core has produced and hands them to one of two memory-side ports. The coherent port takes stores to write-back cacheable memory. The peripheral port takes stores to uncacheable memory, which is treated as sequential. Each store arrives with an address, data, an attribute bit, an ordering bit (unordered or release) and a peripheral-domain number. Stores wait in a small queue until the ordering rules allow them out. Each store leaves with a slot tag, and the port returns that tag on its acknowledge once the store is visible. The acknowledge frees the slot.

Two rules set the order. First, sequential stores to one peripheral domain go out in program order, whatever their ordering bit. Second, a release store waits until every older store has been acknowledged. Cacheable unordered stores wait on nothing. Stores to different peripheral domains are independent of each other. When several stores may go out on the same port, the oldest one goes first.

The reset input is asynchronous and active low. Its release is expected to be synchronized to `clk` outside this block.

Top module: `store_order_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the queue is empty: `in_ready` is 1 and neither port has valid set. Stores held when reset asserts are dropped.
- R2: `in_ready` is 0 exactly when all DEPTH slots are held. A store is taken only in a cycle where `in_valid` and `in_ready` are both 1.
- R3: A store with `in_uc`=0 and `in_rel`=0 goes out on the coherent port. It does not wait for any other store. Stores of this kind may become visible in any order.
- R4: A store with `in_uc`=1 goes out on the peripheral port. It is never issued while an older uncacheable store to the same domain is still unacknowledged, whatever either store's `in_rel` value. As a result, each domain has at most one store in flight.
- R5: Uncacheable stores to different domains do not wait on each other. A store to domain B may leave before an older store to domain A.
- R6: A store with `in_rel`=1 is issued only when no older store, on either port, is still unacknowledged.
- R7: Each port issues at most one store per cycle, as a one-cycle valid pulse. When several stores may leave on a port, the oldest one in program order goes first. The two ports never carry the same tag in one cycle.
- R8: An acknowledge on a port, with the tag that the port issued, frees that slot at the next clock edge. The slot can take a new store in the cycle after that.
- R9: A store is issued exactly once. A tag is not issued again while its earlier store is still unacknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A store is offered |
| in_ready | output | 1 | A slot is free, so an offered store is taken |
| in_addr | input | AW | Store address |
| in_data | input | DW | Store data |
| in_uc | input | 1 | 1 = uncacheable (sequential), 0 = write-back cacheable |
| in_rel | input | 1 | 1 = release, 0 = unordered |
| in_dom | input | DOMW | Peripheral-domain number |
| cc_valid | output | 1 | Coherent port: store issued this cycle |
| cc_addr | output | AW | Coherent port: address |
| cc_data | output | DW | Coherent port: data |
| cc_tag | output | TAGW | Coherent port: slot tag |
| cc_ack | input | 1 | Coherent port: a store is now visible |
| cc_ack_tag | input | TAGW | Coherent port: tag of the visible store |
| uc_valid | output | 1 | Peripheral port: store issued this cycle |
| uc_addr | output | AW | Peripheral port: address |
| uc_data | output | DW | Peripheral port: data |
| uc_dom | output | DOMW | Peripheral port: target domain |
| uc_tag | output | TAGW | Peripheral port: slot tag |
| uc_ack | input | 1 | Peripheral port: a store is now visible |
| uc_ack_tag | input | TAGW | Peripheral port: tag of the visible store |

## Verification
The bench builds the unit with DEPTH=4, 8-bit address and data, and the default 2-bit domain. The small queue fills within a few cycles, so the back-pressure path and the full-then-drain transitions are exercised many times. The store kind cycles arithmetically through all sixteen combinations of attribute, ordering bit and domain. The acknowledge delay is derived from each store's data. Together these cover nearly every ordered pairing of store kinds and nearly every arrival order of acknowledges. A program-order model in the bench predicts, cycle by cycle, which slot each port must issue and whether the queue must accept.

// File: rtl/sou_pkg.sv
package sou_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE   = 2'd0,
    SLOT_WAIT   = 2'd1,
    SLOT_ISSUED = 2'd2
  } slot_state_e;
endpackage

// File: rtl/sou_age_matrix.sv
// Relative-age bookkeeping: older_o[i][j] = 1 when slot j entered before slot i.
module sou_age_matrix #(
  parameter int DEPTH = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [DEPTH-1:0]                 alloc_i,
  input  logic [DEPTH-1:0]                 occ_i,
  output logic [DEPTH-1:0][DEPTH-1:0]      older_o
);
  logic [DEPTH-1:0][DEPTH-1:0] age_q, age_n;
  logic                        age_en;

  assign age_en = |alloc_i;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc_i[i]) age_n[i] = occ_i & ~alloc_i;
      else            age_n[i] = age_q[i] & ~alloc_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      age_q <= '0;
    else if (age_en) age_q <= age_n;
  end

  assign older_o = age_q;
endmodule

// File: rtl/sou_hazard.sv
// Decides which waiting slots satisfy the release and sequential-domain rules.
module sou_hazard #(
  parameter int DEPTH = 8,
  parameter int DOMW  = 2
) (
  input  logic [DEPTH-1:0]            wait_i,
  input  logic [DEPTH-1:0]            occ_i,
  input  logic [DEPTH-1:0]            uc_i,
  input  logic [DEPTH-1:0]            rel_i,
  input  logic [DEPTH-1:0][DOMW-1:0]  dom_i,
  input  logic [DEPTH-1:0][DEPTH-1:0] older_i,
  output logic [DEPTH-1:0]            ok_o
);
  logic [DEPTH-1:0] rel_blk, seq_blk;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      rel_blk[i] = |(older_i[i] & occ_i);
      seq_blk[i] = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if (older_i[i][j] && occ_i[j] && uc_i[j] && (dom_i[j] == dom_i[i]))
          seq_blk[i] = 1'b1;
      end
      ok_o[i] = wait_i[i]
              & ~(rel_i[i] & rel_blk[i])
              & ~(uc_i[i] & seq_blk[i]);
    end
  end
endmodule

// File: rtl/sou_oldest_pick.sv
// One-hot choice of the oldest candidate, plus its encoded index.
module sou_oldest_pick #(
  parameter int DEPTH = 8,
  parameter int TAGW  = 3
) (
  input  logic [DEPTH-1:0]            cand_i,
  input  logic [DEPTH-1:0][DEPTH-1:0] older_i,
  output logic [DEPTH-1:0]            gnt_o,
  output logic                        any_o,
  output logic [TAGW-1:0]             idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      gnt_o[i] = cand_i[i] & ~|(older_i[i] & cand_i);
      if (gnt_o[i]) idx_o = TAGW'(i);
    end
    any_o = |gnt_o;
  end
endmodule

// File: rtl/store_order_unit.sv
module store_order_unit #(
  parameter  int DEPTH = 8,
  parameter  int AW    = 32,
  parameter  int DW    = 32,
  parameter  int DOMW  = 2,
  localparam int TAGW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [AW-1:0]   in_addr,
  input  logic [DW-1:0]   in_data,
  input  logic            in_uc,
  input  logic            in_rel,
  input  logic [DOMW-1:0] in_dom,
  output logic            cc_valid,
  output logic [AW-1:0]   cc_addr,
  output logic [DW-1:0]   cc_data,
  output logic [TAGW-1:0] cc_tag,
  input  logic            cc_ack,
  input  logic [TAGW-1:0] cc_ack_tag,
  output logic            uc_valid,
  output logic [AW-1:0]   uc_addr,
  output logic [DW-1:0]   uc_data,
  output logic [DOMW-1:0] uc_dom,
  output logic [TAGW-1:0] uc_tag,
  input  logic            uc_ack,
  input  logic [TAGW-1:0] uc_ack_tag
);
  import sou_pkg::*;

  slot_state_e                 st_q [DEPTH];
  slot_state_e                 st_n [DEPTH];
  logic [AW-1:0]               addr_q [DEPTH];
  logic [DW-1:0]               data_q [DEPTH];
  logic [DEPTH-1:0]            uc_q, rel_q;
  logic [DEPTH-1:0][DOMW-1:0]  dom_q;

  logic [DEPTH-1:0]            occ, waiting, free_pick, take, ok;
  logic [DEPTH-1:0]            cc_cand, uc_cand, cc_gnt, uc_gnt, retire;
  logic [DEPTH-1:0][DEPTH-1:0] older;
  logic                        accept;

  // slot status
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      occ[i]     = (st_q[i] != SLOT_FREE);
      waiting[i] = (st_q[i] == SLOT_WAIT);
    end
  end

  // lowest free slot takes the next store
  always_comb begin
    logic found;
    found     = 1'b0;
    free_pick = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!occ[i] && !found) begin
        free_pick[i] = 1'b1;
        found        = 1'b1;
      end
    end
  end

  assign in_ready = ~&occ;
  assign accept   = in_valid & in_ready;
  assign take     = accept ? free_pick : '0;

  sou_age_matrix #(.DEPTH(DEPTH)) u_age (
    .clk     (clk),
    .rst_n   (rst_n),
    .alloc_i (take),
    .occ_i   (occ),
    .older_o (older)
  );

  sou_hazard #(.DEPTH(DEPTH), .DOMW(DOMW)) u_haz (
    .wait_i  (waiting),
    .occ_i   (occ),
    .uc_i    (uc_q),
    .rel_i   (rel_q),
    .dom_i   (dom_q),
    .older_i (older),
    .ok_o    (ok)
  );

  assign cc_cand = ok & ~uc_q;
  assign uc_cand = ok & uc_q;

  sou_oldest_pick #(.DEPTH(DEPTH), .TAGW(TAGW)) u_pick_cc (
    .cand_i  (cc_cand),
    .older_i (older),
    .gnt_o   (cc_gnt),
    .any_o   (cc_valid),
    .idx_o   (cc_tag)
  );

  sou_oldest_pick #(.DEPTH(DEPTH), .TAGW(TAGW)) u_pick_uc (
    .cand_i  (uc_cand),
    .older_i (older),
    .gnt_o   (uc_gnt),
    .any_o   (uc_valid),
    .idx_o   (uc_tag)
  );

  // acknowledge decode: the tag must name an issued slot of that port
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      retire[i] = (st_q[i] == SLOT_ISSUED) &&
                  (( cc_ack && (cc_ack_tag == TAGW'(i)) && !uc_q[i]) ||
                   ( uc_ack && (uc_ack_tag == TAGW'(i)) &&  uc_q[i]));
    end
  end

  // next state per slot
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      st_n[i] = st_q[i];
      if (take[i])                          st_n[i] = SLOT_WAIT;
      else if (cc_gnt[i] || uc_gnt[i])      st_n[i] = SLOT_ISSUED;
      else if (retire[i])                   st_n[i] = SLOT_FREE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) st_q[i] <= SLOT_FREE;
    end else begin
      for (int i = 0; i < DEPTH; i++) st_q[i] <= st_n[i];
    end
  end

  // payload: written only when a slot is filled, no reset needed
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (take[i]) begin
        addr_q[i] <= in_addr;
        data_q[i] <= in_data;
        uc_q[i]   <= in_uc;
        rel_q[i]  <= in_rel;
        dom_q[i]  <= in_dom;
      end
    end
  end

  assign cc_addr = addr_q[cc_tag];
  assign cc_data = data_q[cc_tag];
  assign uc_addr = addr_q[uc_tag];
  assign uc_data = data_q[uc_tag];
  assign uc_dom  = dom_q[uc_tag];
endmodule

// File: rtl/sou_chk.sv
module sou_chk #(
  parameter  int DEPTH = 8,
  parameter  int DOMW  = 2,
  localparam int TAGW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1) + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            cc_valid,
  input logic [TAGW-1:0] cc_tag,
  input logic            cc_ack,
  input logic [TAGW-1:0] cc_ack_tag,
  input logic            uc_valid,
  input logic [TAGW-1:0] uc_tag,
  input logic [DOMW-1:0] uc_dom,
  input logic            uc_ack,
  input logic [TAGW-1:0] uc_ack_tag
);
  logic [DEPTH-1:0]           cc_out, uc_out;
  logic [DEPTH-1:0][DOMW-1:0] tag_dom;
  logic [CW-1:0]              held;
  logic [(1<<DOMW)-1:0]       dom_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_out  <= '0;
      uc_out  <= '0;
      tag_dom <= '0;
      held    <= '0;
    end else begin
      if (cc_ack && cc_out[cc_ack_tag]) cc_out[cc_ack_tag] <= 1'b0;
      if (uc_ack && uc_out[uc_ack_tag]) uc_out[uc_ack_tag] <= 1'b0;
      if (cc_valid) cc_out[cc_tag] <= 1'b1;
      if (uc_valid) begin
        uc_out[uc_tag]  <= 1'b1;
        tag_dom[uc_tag] <= uc_dom;
      end
      held <= held + CW'(in_valid && in_ready)
                   - CW'(cc_ack && cc_out[cc_ack_tag])
                   - CW'(uc_ack && uc_out[uc_ack_tag]);
    end
  end

  always_comb begin
    dom_busy = '0;
    for (int t = 0; t < DEPTH; t++)
      if (uc_out[t]) dom_busy[tag_dom[t]] = 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!cc_valid && !uc_valid && in_ready));

  // R2
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held == CW'(DEPTH)) |-> !in_ready);

  // R2
  room_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held < CW'(DEPTH)) |-> in_ready);

  // R4
  one_per_dom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uc_valid |-> !dom_busy[uc_dom]);

  // R7
  port_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_valid && uc_valid) |-> (cc_tag != uc_tag));

  // R9
  cc_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cc_valid |-> !(cc_out[cc_tag] || uc_out[cc_tag]));

  // R9
  uc_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uc_valid |-> !(cc_out[uc_tag] || uc_out[uc_tag]));
endmodule

bind store_order_unit sou_chk #(.DEPTH(DEPTH), .DOMW(DOMW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .cc_valid   (cc_valid),
  .cc_tag     (cc_tag),
  .cc_ack     (cc_ack),
  .cc_ack_tag (cc_ack_tag),
  .uc_valid   (uc_valid),
  .uc_tag     (uc_tag),
  .uc_dom     (uc_dom),
  .uc_ack     (uc_ack),
  .uc_ack_tag (uc_ack_tag)
);

// File: tb/store_order_unit_tb.sv
module store_order_unit_tb;
  localparam int DEPTH = 4;
  localparam int AW    = 8;
  localparam int DW    = 8;
  localparam int DOMW  = 2;
  localparam int TAGW  = 2;
  localparam int MAXM  = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n, in_valid, in_ready, in_uc, in_rel;
  logic [AW-1:0]   in_addr;
  logic [DW-1:0]   in_data;
  logic [DOMW-1:0] in_dom;
  logic            cc_valid, cc_ack, uc_valid, uc_ack;
  logic [AW-1:0]   cc_addr, uc_addr;
  logic [DW-1:0]   cc_data, uc_data;
  logic [DOMW-1:0] uc_dom;
  logic [TAGW-1:0] cc_tag, cc_ack_tag, uc_tag, uc_ack_tag;

  store_order_unit #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .DOMW(DOMW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_data(in_data),
    .in_uc(in_uc), .in_rel(in_rel), .in_dom(in_dom),
    .cc_valid(cc_valid), .cc_addr(cc_addr), .cc_data(cc_data), .cc_tag(cc_tag),
    .cc_ack(cc_ack), .cc_ack_tag(cc_ack_tag),
    .uc_valid(uc_valid), .uc_addr(uc_addr), .uc_data(uc_data), .uc_dom(uc_dom),
    .uc_tag(uc_tag), .uc_ack(uc_ack), .uc_ack_tag(uc_ack_tag)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // program-order model: index 0 is the oldest outstanding store
  int m_cnt = 0;
  int m_data [MAXM];
  bit m_uc   [MAXM];
  bit m_rel  [MAXM];
  int m_dom  [MAXM];
  int m_st   [MAXM];   // 1 waiting, 2 issued
  int m_tag  [MAXM];
  int m_dly  [MAXM];
  int seq = 0;
  int cyc = 0;
  bit push_en = 1'b0;
  bit ack_en  = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit may_go(int e);
    if (m_st[e] != 1) return 1'b0;
    for (int j = 0; j < e; j++) begin
      if (m_rel[e]) return 1'b0;                                   // R6
      if (m_uc[e] && m_uc[j] && m_dom[j] == m_dom[e]) return 1'b0; // R4
    end
    return 1'b1;
  endfunction

  function automatic int oldest_for(bit uc);
    for (int e = 0; e < m_cnt; e++)
      if (m_uc[e] == uc && may_go(e)) return e;
    return -1;
  endfunction

  function automatic int find_data(int d);
    for (int e = 0; e < m_cnt; e++)
      if (m_data[e] == d) return e;
    return -1;
  endfunction

  task automatic model_clear();
    m_cnt = 0;
  endtask

  // one cycle, entered just after a falling edge
  task automatic step();
    int ec, eu, ic, iu, k, w;
    bit kill [MAXM];
    bit got_cc, got_uc;
    for (int e = 0; e < MAXM; e++) kill[e] = 1'b0;

    chk(in_ready === (m_cnt < DEPTH), "R2 R8 ready", int'(in_ready), int'(m_cnt < DEPTH));

    ec = oldest_for(1'b0);
    eu = oldest_for(1'b1);

    chk(cc_valid === (ec >= 0), "R3 R6 R7 cc issue", int'(cc_valid), int'(ec >= 0));
    if (cc_valid && ec >= 0)
      chk(int'(cc_data) == m_data[ec] && int'(cc_addr) == (m_data[ec] ^ 8'h5A),
          "R3 R6 R7 cc oldest", int'(cc_data), m_data[ec]);
    chk(uc_valid === (eu >= 0), "R4 R5 R6 R7 uc issue", int'(uc_valid), int'(eu >= 0));
    if (uc_valid && eu >= 0)
      chk(int'(uc_data) == m_data[eu] && int'(uc_dom) == m_dom[eu] &&
          int'(uc_addr) == (m_data[eu] ^ 8'h5A),
          "R4 R5 R7 uc oldest", int'(uc_data), m_data[eu]);

    // acknowledges for stores issued in earlier cycles
    got_cc = 1'b0; got_uc = 1'b0;
    cc_ack = 1'b0; uc_ack = 1'b0; cc_ack_tag = '0; uc_ack_tag = '0;
    if (ack_en) begin
      for (int e = 0; e < m_cnt; e++) begin
        if (m_st[e] == 2 && m_dly[e] == 0) begin
          if (!m_uc[e] && !got_cc) begin
            got_cc = 1'b1; cc_ack = 1'b1; cc_ack_tag = TAGW'(m_tag[e]); kill[e] = 1'b1;
          end else if (m_uc[e] && !got_uc) begin
            got_uc = 1'b1; uc_ack = 1'b1; uc_ack_tag = TAGW'(m_tag[e]); kill[e] = 1'b1;
          end
        end
      end
    end
    for (int e = 0; e < m_cnt; e++)
      if (m_st[e] == 2 && m_dly[e] > 0) m_dly[e]--;

    if (cc_valid) begin
      ic = find_data(int'(cc_data));
      chk(ic >= 0 && m_st[ic] == 1, "R9 cc single issue", (ic >= 0) ? m_st[ic] : -1, 1);
      if (ic >= 0) begin m_st[ic] = 2; m_tag[ic] = int'(cc_tag); m_dly[ic] = 1 + (m_data[ic] % 3); end
    end
    if (uc_valid) begin
      iu = find_data(int'(uc_data));
      chk(iu >= 0 && m_st[iu] == 1, "R9 uc single issue", (iu >= 0) ? m_st[iu] : -1, 1);
      if (iu >= 0) begin m_st[iu] = 2; m_tag[iu] = int'(uc_tag); m_dly[iu] = 1 + ((m_data[iu] * 7) % 4); end
    end

    // new store
    in_valid = push_en && ((cyc % 7) != 6);
    k = (seq * 5 + (seq >> 4)) % 16;
    in_data = DW'(seq);
    in_addr = AW'(seq ^ 8'h5A);
    in_uc   = k[0];
    in_rel  = k[1];
    in_dom  = DOMW'(k >> 2);
    if (in_valid && in_ready) begin
      m_data[m_cnt] = seq % 256;
      m_uc[m_cnt]   = in_uc;
      m_rel[m_cnt]  = in_rel;
      m_dom[m_cnt]  = int'(in_dom);
      m_st[m_cnt]   = 1;
      m_tag[m_cnt]  = 0;
      m_dly[m_cnt]  = 0;
      m_cnt++;
      seq++;
    end

    // retire acknowledged stores (R8), keeping program order
    w = 0;
    for (int e = 0; e < m_cnt; e++) begin
      if (!kill[e]) begin
        m_data[w] = m_data[e]; m_uc[w] = m_uc[e]; m_rel[w] = m_rel[e]; m_dom[w] = m_dom[e];
        m_st[w] = m_st[e]; m_tag[w] = m_tag[e]; m_dly[w] = m_dly[e];
        w++;
      end
    end
    m_cnt = w;
    cyc++;
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic drain();
    push_en = 1'b0; ack_en = 1'b1;
    for (int i = 0; i < 300 && m_cnt > 0; i++) step();
    chk(m_cnt == 0, "R8 drain", m_cnt, 0);
    chk(in_ready === 1'b1 && !cc_valid && !uc_valid, "R8 empty after drain",
        int'(in_ready), 1);
  endtask

  task automatic idle_check(input string tag);
    chk(in_ready === 1'b1, tag, int'(in_ready), 1);
    chk(cc_valid === 1'b0 && uc_valid === 1'b0, tag, int'(cc_valid) + int'(uc_valid), 0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; in_data = '0; in_uc = 1'b0;
    in_rel = 1'b0; in_dom = '0; cc_ack = 1'b0; uc_ack = 1'b0;
    cc_ack_tag = '0; uc_ack_tag = '0;
    repeat (3) @(negedge clk);
    idle_check("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("R1 after reset");

    // mixed stream over all kinds
    push_en = 1'b1; ack_en = 1'b1;
    run(1500);
    // hold acknowledges: queue fills and stalls, then recovers
    ack_en = 1'b0;
    run(20);
    chk(in_ready === 1'b0, "R2 full stall", int'(in_ready), 0);
    ack_en = 1'b1;
    run(200);
    drain();

    // reset with stores outstanding
    push_en = 1'b1; ack_en = 1'b0;
    run(6);
    rst_n = 1'b0;
    in_valid = 1'b0; cc_ack = 1'b0; uc_ack = 1'b0;
    model_clear();
    @(negedge clk);
    idle_check("R1 reset drops stores");
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("R1 after second reset");

    push_en = 1'b1; ack_en = 1'b1;
    run(400);
    drain();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule